// File: doc/BRIEF.md
# Accumulator Subtract/Logic Unit with Flag Update

This block is the execute slice of a small 8-bit accumulator machine. It holds two byte accumulators (which also act together as a 16-bit word, the first one supplying the high byte), two 16-bit index registers, a 16-bit stack pointer and an 8-bit condition register. Each enabled cycle it takes an operation code, a destination select and a 16-bit memory operand. It performs one operation from a fixed family: byte subtract, word subtract, accumulator-to-accumulator subtract, two's-complement negate, decrement, bitwise AND, OR, XOR, and one's complement. It then writes the result into the selected register or drives it out as a memory write byte.

Each operation touches only its own set of flags. Some flags are computed, some are forced to a constant, and the rest keep their value. An upstream sequencer is expected to fetch and decode instructions, generate addresses, and feed the operand bytes in on `memIn`.

Top module: `accAlu`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both accumulators, both index registers, the stack pointer and the condition register to zero. Condition bits are: 3 = N (negative), 2 = Z (zero), 1 = V (overflow), 0 = C (borrow), and bits 7..4 are control bits.
- R2: Op 0 with destination 0 (accumulator A) or 1 (accumulator B) subtracts `memIn[7:0]` from that accumulator and stores the difference. N is the result MSB, Z is set for a zero result, V is set for a signed overflow, and C is the borrow out.
- R3: Op 1 subtracts the whole of `memIn` (high byte first) from the word {A,B}, writes the result back to A (high) and B (low), and computes N, Z, V and C over all 16 bits.
- R4: Op 2 computes A minus B into A, leaves B unchanged, and computes N, Z, V and C.
- R5: Op 3 replaces A (dst 0), B (dst 1) or the memory byte (dst 2) with zero minus the operand. C is set exactly when the operand is non-zero, V exactly when it is 0x80, and N and Z follow the result.
- R6: Op 4 on A, B or memory (dst 0..2) subtracts one and updates N, Z and V (V set only when the operand was 0x80). C keeps its value.
- R7: Op 4 on X (dst 3) or Y (dst 4) subtracts one from the 16-bit register and updates only Z. On the stack pointer (dst 5) it subtracts one and changes no flag.
- R8: Ops 5 (AND), 6 (OR) and 7 (XOR) with dst 0 or 1 combine the accumulator with `memIn[7:0]` into that accumulator. N and Z follow the result, V is cleared, and C keeps its value.
- R9: Op 8 inverts all bits of A, B or the memory byte (dst 0..2). N and Z follow the result, V is cleared, and C is set.
- R10: Condition bits 7..4 are never changed by any operation.
- R11: For a memory destination (dst 2) of ops 3, 4 or 8, the result appears combinationally on `memOut` with `memWe` high during the enabled cycle. No register except the condition register changes.
- R12: With `en` low, or with an op/destination pairing not listed above, no register and no flag changes and `memWe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Execute the presented operation this cycle |
| op | input | 4 | Operation code (0..8) |
| dst | input | 3 | Destination select: 0 A, 1 B, 2 memory, 3 X, 4 Y, 5 stack |
| memIn | input | 16 | Memory operand; byte ops use bits 7..0 |
| memOut | output | 8 | Result byte for a memory destination |
| memWe | output | 1 | Memory write strobe |
| accA | output | 8 | Accumulator A |
| accB | output | 8 | Accumulator B |
| idxX | output | 16 | Index register X |
| idxY | output | 16 | Index register Y |
| stackP | output | 16 | Stack pointer |
| ccr | output | 8 | Condition register |

## Verification
The bound checker checks on every cycle the properties that depend on the operation class alone. The control bits never move. An idle or rejected cycle freezes all state. A stack decrement leaves every flag alone. Decrements, AND, OR and XOR keep C, and one's complement forces V=0 and C=1. The negate borrow on a memory operand follows whether that operand was zero. The arithmetic values need the directed scenarios: the byte and word differences, signed overflow at the 0x80/0x7F boundaries, Z over a full 16-bit result, and how results reach `memOut`. The scenarios include the worked subtraction examples, negate of 0x80 and of zero, and decrement across the sign boundary.

// File: rtl/accAluPkg.sv
package accAluPkg;
  typedef enum logic [3:0] {
    OP_SUB  = 4'd0,
    OP_SUBW = 4'd1,
    OP_SBA  = 4'd2,
    OP_NEG  = 4'd3,
    OP_DEC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_COM  = 4'd8
  } aluOp_e;

  typedef enum logic [2:0] {
    DST_A = 3'd0,
    DST_B = 3'd1,
    DST_M = 3'd2,
    DST_X = 3'd3,
    DST_Y = 3'd4,
    DST_S = 3'd5
  } dstSel_e;

  // flag order inside flagMask: {N, Z, V, C}
  typedef struct packed {
    logic       wrA;
    logic       wrB;
    logic       wrX;
    logic       wrY;
    logic       wrS;
    logic       memWe;
    logic [3:0] flagMask;
  } ctrl_t;
endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic       en,
  input  logic [3:0] op,
  input  logic [2:0] dst,
  output ctrl_t      ctrl
);
  aluOp_e  opE;
  dstSel_e dstE;
  logic    accDst;
  logic    byteDst;

  assign opE     = aluOp_e'(op);
  assign dstE    = dstSel_e'(dst);
  assign accDst  = (dstE == DST_A) || (dstE == DST_B);
  assign byteDst = accDst || (dstE == DST_M);

  always_comb begin
    ctrl = '0;
    if (en) begin
      unique case (opE)
        OP_SUB: if (accDst) begin
          ctrl.wrA = (dstE == DST_A);
          ctrl.wrB = (dstE == DST_B);
          ctrl.flagMask = 4'b1111;
        end
        OP_SUBW: begin
          ctrl.wrA = 1'b1;
          ctrl.wrB = 1'b1;
          ctrl.flagMask = 4'b1111;
        end
        OP_SBA: begin
          ctrl.wrA = 1'b1;
          ctrl.flagMask = 4'b1111;
        end
        OP_NEG, OP_COM: if (byteDst) begin
          ctrl.wrA   = (dstE == DST_A);
          ctrl.wrB   = (dstE == DST_B);
          ctrl.memWe = (dstE == DST_M);
          ctrl.flagMask = 4'b1111;
        end
        OP_DEC: begin
          if (byteDst) begin
            ctrl.wrA   = (dstE == DST_A);
            ctrl.wrB   = (dstE == DST_B);
            ctrl.memWe = (dstE == DST_M);
            ctrl.flagMask = 4'b1110;
          end else if (dstE == DST_X || dstE == DST_Y) begin
            ctrl.wrX = (dstE == DST_X);
            ctrl.wrY = (dstE == DST_Y);
            ctrl.flagMask = 4'b0100;
          end else if (dstE == DST_S) begin
            ctrl.wrS = 1'b1;
          end
        end
        OP_AND, OP_OR, OP_XOR: if (accDst) begin
          ctrl.wrA = (dstE == DST_A);
          ctrl.wrB = (dstE == DST_B);
          ctrl.flagMask = 4'b1110;
        end
        default: ctrl = '0;
      endcase
    end
  end
endmodule

// File: rtl/accAluPath.sv
module accAluPath
  import accAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          op,
  input  logic [2:0]          dst,
  input  logic [2*DATA_W-1:0] memIn,
  input  ctrl_t               ctrl,
  output logic [DATA_W-1:0]   memOut,
  output logic [DATA_W-1:0]   accA,
  output logic [DATA_W-1:0]   accB,
  output logic [2*DATA_W-1:0] idxX,
  output logic [2*DATA_W-1:0] idxY,
  output logic [2*DATA_W-1:0] stackP,
  output logic [7:0]          ccr
);
  localparam int WORD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] SIGN_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

  aluOp_e  opE;
  dstSel_e dstE;
  logic [DATA_W-1:0] lhs8, rhs8, res8;
  logic [WORD_W-1:0] lhs16, res16, idxSel;
  logic              brw8, brw16;
  logic              nF, zF, vF, cF;
  logic [3:0]        newFlags;

  assign opE  = aluOp_e'(op);
  assign dstE = dstSel_e'(dst);

  always_comb begin
    if (opE == OP_SBA || dstE == DST_A) lhs8 = accA;
    else if (dstE == DST_B)             lhs8 = accB;
    else                                lhs8 = memIn[DATA_W-1:0];
    rhs8 = (opE == OP_SBA) ? accB : memIn[DATA_W-1:0];
    unique case (dstE)
      DST_X:   idxSel = idxX;
      DST_Y:   idxSel = idxY;
      default: idxSel = stackP;
    endcase
  end

  assign lhs16 = {accA, accB};

  always_comb begin
    res8  = '0;
    res16 = '0;
    brw8  = 1'b0;
    brw16 = 1'b0;
    nF = 1'b0; zF = 1'b0; vF = 1'b0; cF = 1'b0;
    unique case (opE)
      OP_SUB, OP_SBA: begin
        {brw8, res8} = {1'b0, lhs8} - {1'b0, rhs8};
        nF = res8[DATA_W-1];
        zF = (res8 == '0);
        vF = (lhs8[DATA_W-1] ^ rhs8[DATA_W-1]) & (res8[DATA_W-1] ^ lhs8[DATA_W-1]);
        cF = brw8;
      end
      OP_SUBW: begin
        {brw16, res16} = {1'b0, lhs16} - {1'b0, memIn};
        nF = res16[WORD_W-1];
        zF = (res16 == '0);
        vF = (lhs16[WORD_W-1] ^ memIn[WORD_W-1]) & (res16[WORD_W-1] ^ lhs16[WORD_W-1]);
        cF = brw16;
      end
      OP_NEG: begin
        res8 = '0 - lhs8;
        nF = res8[DATA_W-1];
        zF = (res8 == '0);
        vF = (lhs8 == SIGN_ONLY);
        cF = (lhs8 != '0);
      end
      OP_DEC: begin
        res8  = lhs8 - 1'b1;
        res16 = idxSel - 1'b1;
        nF = res8[DATA_W-1];
        zF = (dstE == DST_X || dstE == DST_Y) ? (res16 == '0) : (res8 == '0);
        vF = (lhs8 == SIGN_ONLY);
      end
      OP_AND, OP_OR, OP_XOR, OP_COM: begin
        if (opE == OP_AND)      res8 = lhs8 & rhs8;
        else if (opE == OP_OR)  res8 = lhs8 | rhs8;
        else if (opE == OP_XOR) res8 = lhs8 ^ rhs8;
        else                    res8 = ~lhs8;
        nF = res8[DATA_W-1];
        zF = (res8 == '0);
        cF = (opE == OP_COM);
      end
      default: ;
    endcase
  end

  assign newFlags = {nF, zF, vF, cF};
  assign memOut   = res8;

  always_ff @(posedge clk) begin
    if (rst) begin
      accA   <= '0;
      accB   <= '0;
      idxX   <= '0;
      idxY   <= '0;
      stackP <= '0;
      ccr    <= '0;
    end else begin
      if (ctrl.wrA) accA <= (opE == OP_SUBW) ? res16[WORD_W-1:DATA_W] : res8;
      if (ctrl.wrB) accB <= (opE == OP_SUBW) ? res16[DATA_W-1:0] : res8;
      if (ctrl.wrX) idxX   <= res16;
      if (ctrl.wrY) idxY   <= res16;
      if (ctrl.wrS) stackP <= res16;
      ccr[3:0] <= (ctrl.flagMask & newFlags) | (~ctrl.flagMask & ccr[3:0]);
    end
  end
endmodule

// File: rtl/accAlu.sv
module accAlu
  import accAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [3:0]          op,
  input  logic [2:0]          dst,
  input  logic [2*DATA_W-1:0] memIn,
  output logic [DATA_W-1:0]   memOut,
  output logic                memWe,
  output logic [DATA_W-1:0]   accA,
  output logic [DATA_W-1:0]   accB,
  output logic [2*DATA_W-1:0] idxX,
  output logic [2*DATA_W-1:0] idxY,
  output logic [2*DATA_W-1:0] stackP,
  output logic [7:0]          ccr
);
  ctrl_t ctrl;

  accAluCtrl u_ctrl (
    .en   (en),
    .op   (op),
    .dst  (dst),
    .ctrl (ctrl)
  );

  accAluPath #(.DATA_W(DATA_W)) u_path (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .dst    (dst),
    .memIn  (memIn),
    .ctrl   (ctrl),
    .memOut (memOut),
    .accA   (accA),
    .accB   (accB),
    .idxX   (idxX),
    .idxY   (idxY),
    .stackP (stackP),
    .ccr    (ccr)
  );

  assign memWe = ctrl.memWe;
endmodule

// File: rtl/accAluChecker.sv
module accAluChecker #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                en,
  input logic [3:0]          op,
  input logic [2:0]          dst,
  input logic [2*DATA_W-1:0] memIn,
  input logic                memWe,
  input logic [DATA_W-1:0]   accA,
  input logic [DATA_W-1:0]   accB,
  input logic [2*DATA_W-1:0] idxX,
  input logic [2*DATA_W-1:0] idxY,
  input logic [2*DATA_W-1:0] stackP,
  input logic [7:0]          ccr
);
  a_r10_ctrl_bits_fixed: assert property (@(posedge clk) disable iff (rst)
    ccr[7:4] == 4'b0000);

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable({accA, accB, idxX, idxY, stackP, ccr}));

  a_r12_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !en |-> !memWe);

  a_r7_stack_no_flags: assert property (@(posedge clk) disable iff (rst)
    (en && op == 4'd4 && dst == 3'd5) |=> $stable(ccr));

  a_r6_dec_keeps_c: assert property (@(posedge clk) disable iff (rst)
    (en && op == 4'd4 && dst <= 3'd2) |=> $stable(ccr[0]));

  a_r8_logic_flags: assert property (@(posedge clk) disable iff (rst)
    (en && op >= 4'd5 && op <= 4'd7 && dst <= 3'd1) |=> (!ccr[1] && $stable(ccr[0])));

  a_r9_com_flags: assert property (@(posedge clk) disable iff (rst)
    (en && op == 4'd8 && dst <= 3'd2) |=> (ccr[1:0] == 2'b01));

  a_r5_neg_mem_borrow: assert property (@(posedge clk) disable iff (rst)
    (en && op == 4'd3 && dst == 3'd2) |=> (ccr[0] == ($past(memIn[DATA_W-1:0]) != '0)));

  a_r11_mem_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    memWe |=> $stable({accA, accB, idxX, idxY, stackP}));
endmodule

bind accAlu accAluChecker #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .op     (op),
  .dst    (dst),
  .memIn  (memIn),
  .memWe  (memWe),
  .accA   (accA),
  .accB   (accB),
  .idxX   (idxX),
  .idxY   (idxY),
  .stackP (stackP),
  .ccr    (ccr)
);

// File: tb/accAlu_test.sv
module accAlu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [3:0]  op = '0;
  logic [2:0]  dst = '0;
  logic [15:0] memIn = '0;
  logic [7:0]  memOut;
  logic        memWe;
  logic [7:0]  accA, accB, ccr;
  logic [15:0] idxX, idxY, stackP;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] SUB = 0, SUBW = 1, SBA = 2, NEG = 3, DEC = 4,
                         ANDO = 5, ORO = 6, XORO = 7, COM = 8;
  localparam logic [2:0] DA = 0, DB = 1, DM = 2, DX = 3, DY = 4, DS = 5;

  always #5 clk = ~clk;

  accAlu uut (
    .clk(clk), .rst(rst), .en(en), .op(op), .dst(dst), .memIn(memIn),
    .memOut(memOut), .memWe(memWe), .accA(accA), .accB(accB),
    .idxX(idxX), .idxY(idxY), .stackP(stackP), .ccr(ccr)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [2:0] d, input logic [15:0] m);
    @(negedge clk);
    op = o; dst = d; memIn = m; en = 1'b1;
    @(posedge clk);
    #1 en = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic setA(input logic [7:0] v);
    step(ANDO, DA, 16'h0000);
    step(ORO, DA, {8'h00, v});
  endtask

  task automatic setB(input logic [7:0] v);
    step(ANDO, DB, 16'h0000);
    step(ORO, DB, {8'h00, v});
  endtask

  task automatic tReset();
    doReset();
    check("R1 accA", {8'h0, accA}, 16'h0);
    check("R1 accB", {8'h0, accB}, 16'h0);
    check("R1 idxX", idxX, 16'h0);
    check("R1 idxY", idxY, 16'h0);
    check("R1 stackP", stackP, 16'h0);
    check("R1 ccr", {8'h0, ccr}, 16'h0);
  endtask

  task automatic tSub8();
    doReset();
    setA(8'h80);
    step(SUB, DA, 16'h0065);
    check("R2 A result", {8'h0, accA}, 16'h001B);
    check("R2 A flags", {12'h0, ccr[3:0]}, 16'h2);
    setB(8'h2F);
    step(SUB, DB, 16'h00D6);
    check("R2 B result", {8'h0, accB}, 16'h0059);
    check("R2 B flags", {12'h0, ccr[3:0]}, 16'h1);
  endtask

  task automatic tSubWord();
    doReset();
    setA(8'h80); setB(8'h2F);
    step(SUBW, DA, 16'h2233);
    check("R3 word result", {accA, accB}, 16'h5DFC);
    check("R3 word flags", {12'h0, ccr[3:0]}, 16'h2);
    setA(8'h12); setB(8'h34);
    step(SUBW, DA, 16'h1234);
    check("R3 word zero", {accA, accB}, 16'h0000);
    check("R3 word zero flags", {12'h0, ccr[3:0]}, 16'h4);
  endtask

  task automatic tSba();
    doReset();
    setA(8'h10); setB(8'h20);
    step(SBA, DB, 16'h00FF);
    check("R4 A result", {8'h0, accA}, 16'h00F0);
    check("R4 B kept", {8'h0, accB}, 16'h0020);
    check("R4 flags", {12'h0, ccr[3:0]}, 16'h9);
  endtask

  task automatic tNeg();
    doReset();
    setA(8'h80);
    step(NEG, DA, 16'h0000);
    check("R5 neg 80", {8'h0, accA}, 16'h0080);
    check("R5 neg 80 flags", {12'h0, ccr[3:0]}, 16'hB);
    setB(8'h00);
    step(NEG, DB, 16'h0000);
    check("R5 neg 0", {8'h0, accB}, 16'h0000);
    check("R5 neg 0 flags", {12'h0, ccr[3:0]}, 16'h4);
    setA(8'h01);
    step(NEG, DA, 16'h0000);
    check("R5 neg 1", {8'h0, accA}, 16'h00FF);
    check("R5 neg 1 flags", {12'h0, ccr[3:0]}, 16'h9);
  endtask

  task automatic tDec();
    doReset();
    setA(8'h80); setB(8'h01);
    step(SUB, DB, 16'h0002);
    check("R6 setup borrow", {12'h0, ccr[3:0]}, 16'h9);
    step(DEC, DA, 16'h0000);
    check("R6 dec 80", {8'h0, accA}, 16'h007F);
    check("R6 dec 80 flags", {12'h0, ccr[3:0]}, 16'h3);
    step(DEC, DA, 16'h0000);
    check("R6 dec 7F flags", {12'h0, ccr[3:0]}, 16'h1);
    step(DEC, DB, 16'h0000);
    check("R6 dec B", {8'h0, accB}, 16'h00FE);
    check("R6 dec B flags", {12'h0, ccr[3:0]}, 16'h9);
  endtask

  task automatic tDecIdx();
    doReset();
    setA(8'h80);
    step(NEG, DA, 16'h0000);
    step(DEC, DX, 16'h0000);
    check("R7 X value", idxX, 16'hFFFF);
    check("R7 X flags", {12'h0, ccr[3:0]}, 16'hB);
    setA(8'h00);
    check("R7 setup Z", {12'h0, ccr[3:0]}, 16'h5);
    step(DEC, DY, 16'h0000);
    check("R7 Y value", idxY, 16'hFFFF);
    check("R7 Y clears Z only", {12'h0, ccr[3:0]}, 16'h1);
    setA(8'h00);
    step(DEC, DS, 16'h0000);
    check("R7 S value", stackP, 16'hFFFF);
    check("R7 S no flags", {12'h0, ccr[3:0]}, 16'h5);
  endtask

  task automatic tLogic();
    doReset();
    setB(8'h01);
    step(SUB, DB, 16'h0002);
    setA(8'hF0);
    step(XORO, DA, 16'h000F);
    check("R8 xor", {8'h0, accA}, 16'h00FF);
    check("R8 xor flags", {12'h0, ccr[3:0]}, 16'h9);
    step(ANDO, DA, 16'h000F);
    check("R8 and", {8'h0, accA}, 16'h000F);
    check("R8 and flags", {12'h0, ccr[3:0]}, 16'h1);
    setA(8'h80);
    step(SUB, DA, 16'h0001);
    check("R8 setup V", {12'h0, ccr[3:0]}, 16'h2);
    step(ANDO, DA, 16'h0000);
    check("R8 V cleared", {12'h0, ccr[3:0]}, 16'h4);
  endtask

  task automatic tCom();
    doReset();
    setA(8'h43);
    step(ORO, DA, 16'h00C6);
    check("R8 or", {8'h0, accA}, 16'h00C7);
    step(COM, DA, 16'h0000);
    check("R9 com A", {8'h0, accA}, 16'h0038);
    check("R9 com A flags", {12'h0, ccr[3:0]}, 16'h1);
    step(COM, DB, 16'h0000);
    check("R9 com B", {8'h0, accB}, 16'h00FF);
    check("R9 com B flags", {12'h0, ccr[3:0]}, 16'h9);
    check("R10 control bits", {8'h0, ccr}, {8'h0, 4'h0, ccr[3:0]});
  endtask

  task automatic tMem();
    doReset();
    setA(8'h55);
    @(negedge clk);
    op = NEG; dst = DM; memIn = 16'h0001; en = 1'b1;
    #1;
    check("R11 neg mem out", {8'h0, memOut}, 16'h00FF);
    check("R11 neg mem we", {15'h0, memWe}, 16'h1);
    @(posedge clk);
    #1 en = 1'b0;
    check("R11 A kept", {8'h0, accA}, 16'h0055);
    check("R11 neg flags", {12'h0, ccr[3:0]}, 16'h9);
    @(negedge clk);
    op = COM; dst = DM; memIn = 16'h000F; en = 1'b1;
    #1;
    check("R11 com mem out", {8'h0, memOut}, 16'h00F0);
    @(posedge clk);
    #1 en = 1'b0;
    check("R11 B kept", {8'h0, accB}, 16'h0000);
  endtask

  task automatic tIgnore();
    doReset();
    setA(8'h3C);
    @(negedge clk);
    op = SUB; dst = DA; memIn = 16'h0001; en = 1'b0;
    @(posedge clk);
    #1;
    check("R12 idle A", {8'h0, accA}, 16'h003C);
    check("R12 idle flags", {12'h0, ccr[3:0]}, 16'h0);
    step(ANDO, DX, 16'h0000);
    check("R12 bad pair X", idxX, 16'h0000);
    check("R12 bad pair flags", {12'h0, ccr[3:0]}, 16'h0);
    @(negedge clk);
    op = SUB; dst = DM; memIn = 16'h0001; en = 1'b1;
    #1;
    check("R12 bad pair no write", {15'h0, memWe}, 16'h0);
    @(posedge clk);
    #1 en = 1'b0;
    check("R12 bad pair A", {8'h0, accA}, 16'h003C);
  endtask

  initial begin
    tReset();
    tSub8();
    tSubWord();
    tSba();
    tNeg();
    tDec();
    tDecIdx();
    tLogic();
    tCom();
    tMem();
    tIgnore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule